// File: doc/BRIEF.md
# Eight-Point Inverse DCT Row Engine

This block performs one eight-point, one-dimensional inverse discrete cosine transform. In a two-dimensional 8x8 transform the same engine is used twice: once across rows, then, after a transposing double buffer, once across columns. This block is only the single pass. The buffer and the second pass sit outside it.

Signed samples arrive one at a time on a stream that carries a valid flag and a start-of-vector marker. They collect in an eight-entry shift register. When the eighth sample is taken, the engine does two things in parallel. It forms four even partial sums from samples 0, 2, 4 and 6, and four odd partial sums from samples 1, 3, 5 and 7. Both sets use fixed Q15 cosine weights. A butterfly then turns each even/odd pair into one sum and one difference. Every result is rounded, shifted down by 15 bits and clamped to the output width. All eight results appear together on a wide bus, marked by a one-cycle done pulse. The results stay unchanged until the next vector completes, so the next vector can load while the current results are read.

Top module: `idct8_row`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `out_valid` is 0 and every bit of `out_data` is 0.
- R2: The sample that arrives with `in_first`=1 is x0. The next seven accepted samples are x1 to x7, in order. Output word k (k = 0..7) occupies `out_data[16k+15:16k]`.
- R3: Let c(k,n) = 23170 for n = 0. Otherwise c(k,n) = ±{32138, 30274, 27246, 23170, 18205, 12540, 6393}[j-1], where j is ((2k+1)·n mod 32) folded into 1..8 through cosine symmetry. The raw value for word k is S_k = Σ x_n·c(k,n). Partial sums for k = 0..3 use only even-index inputs (even part) or only odd-index inputs (odd part), each accumulated at full width.
- R4: For k = 0..3, word k is built from E_k+O_k and word 7-k from E_k-O_k. With all odd-index inputs at zero, word k therefore equals word 7-k.
- R5: Each word is (S_k + 2^14) shifted right arithmetically by 15 bits.
- R6: A result above +32767 is reported as +32767, and one below -32768 as -32768.
- R7: `out_valid` is high for exactly one cycle, two clock edges after the edge that accepts the eighth sample. `out_data` holds its value until the next such pulse.
- R8: A sample offered without `in_first` while no vector is being collected (after reset, or after a vector has completed) is dropped and never produces a pulse. An `in_first` in the middle of a vector discards the partial vector and starts a new one.
- R9: Idle cycles between the samples of a vector do not change its result.
- R10: A new vector may start on the cycle right after the previous vector's eighth sample. Both vectors then produce their own correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered this cycle |
| in_first | input | 1 | The offered sample is x0 of a new vector |
| in_sample | input | SAMPLE_W (12) | Signed input sample |
| out_valid | output | 1 | One-cycle done pulse |
| out_data | output | 8·OUT_W (128) | Eight signed result words, word k in bits [16k+15:16k] |

## Verification
The hardest case to reach from the ports is the clamp. With 12-bit samples, even the largest row weight total keeps every result far inside 16 bits, so the default instance can never saturate. The bench therefore adds a second instance with 16-bit samples and drives full-scale vectors with alternating signs, which pushes results past both limits. A second hard case is overlap: results must come out while the next vector is already shifting in. The bench covers this by loading two vectors back to back, with a checker running in parallel that samples the first result in the middle of the second load.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int COEF_W    = 16;
    localparam int FRAC_BITS = 15;
    localparam int VEC_LEN   = 8;
    localparam int HALF_LEN  = VEC_LEN / 2;
    localparam int CNT_W     = $clog2(VEC_LEN + 1);

    typedef enum logic [0:0] {
        LD_IDLE = 1'b0,
        LD_FILL = 1'b1
    } ld_state_e;

    // Q15 cosine weight for output k, input n of the 8-point inverse transform.
    function automatic logic signed [COEF_W-1:0] basis_coef(input int k, input int n);
        int  j;
        int  mag;
        bit  neg;
        if (n == 0) begin
            return COEF_W'(23170);
        end
        j   = ((2 * k + 1) * n) % 32;
        neg = 1'b0;
        if (j > 16) j = 32 - j;
        if (j > 8) begin
            j   = 16 - j;
            neg = 1'b1;
        end
        case (j)
            1:       mag = 32138;
            2:       mag = 30274;
            3:       mag = 27246;
            4:       mag = 23170;
            5:       mag = 18205;
            6:       mag = 12540;
            7:       mag = 6393;
            default: mag = 0;
        endcase
        return neg ? COEF_W'(-mag) : COEF_W'(mag);
    endfunction

endpackage

// File: rtl/idct8_loader.sv
module idct8_loader
    import idct8_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_first,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic signed [SAMPLE_W-1:0] vec_o [VEC_LEN],
    output logic                       go_o
);

    ld_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] next_cnt;
    logic             accept;

    assign accept   = in_valid && (in_first || (st == LD_FILL));
    assign next_cnt = in_first ? CNT_W'(1) : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LD_IDLE;
            cnt  <= '0;
            go_o <= 1'b0;
            for (int i = 0; i < VEC_LEN; i++) vec_o[i] <= '0;
        end else begin
            go_o <= 1'b0;
            if (accept) begin
                for (int i = 0; i < VEC_LEN - 1; i++) vec_o[i] <= vec_o[i+1];
                vec_o[VEC_LEN-1] <= in_sample;
                if (next_cnt == CNT_W'(VEC_LEN)) begin
                    st   <= LD_IDLE;
                    cnt  <= '0;
                    go_o <= 1'b1;
                end else begin
                    st  <= LD_FILL;
                    cnt <= next_cnt;
                end
            end
        end
    end

    assert_go_single_R7: assert property (@(posedge clk) disable iff (rst)
        go_o |=> !go_o);

    assert_stray_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (st == LD_IDLE && in_valid && !in_first) |=> (!go_o && st == LD_IDLE));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(cnt) && !go_o));

endmodule

// File: rtl/idct8_partials.sv
module idct8_partials
    import idct8_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = SAMPLE_W + COEF_W + 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] vec_i [VEC_LEN],
    input  logic                       go_i,
    output logic signed [ACC_W-1:0]    even_o [HALF_LEN],
    output logic signed [ACC_W-1:0]    odd_o  [HALF_LEN],
    output logic                       valid_o
);

    logic signed [ACC_W-1:0] even_n [HALF_LEN];
    logic signed [ACC_W-1:0] odd_n  [HALF_LEN];

    always_comb begin
        for (int k = 0; k < HALF_LEN; k++) begin
            even_n[k] = '0;
            odd_n[k]  = '0;
            for (int n = 0; n < VEC_LEN; n++) begin
                if ((n % 2) == 0)
                    even_n[k] = even_n[k] + ACC_W'(vec_i[n]) * ACC_W'(basis_coef(k, n));
                else
                    odd_n[k]  = odd_n[k]  + ACC_W'(vec_i[n]) * ACC_W'(basis_coef(k, n));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            for (int k = 0; k < HALF_LEN; k++) begin
                even_o[k] <= '0;
                odd_o[k]  <= '0;
            end
        end else begin
            valid_o <= go_i;
            if (go_i) begin
                for (int k = 0; k < HALF_LEN; k++) begin
                    even_o[k] <= even_n[k];
                    odd_o[k]  <= odd_n[k];
                end
            end
        end
    end

    assert_stage_follows_R7: assert property (@(posedge clk) disable iff (rst)
        go_i |=> valid_o);

endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly
    import idct8_pkg::*;
#(
    parameter int ACC_W = 31,
    parameter int OUT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic signed [ACC_W-1:0]     even_i [HALF_LEN],
    input  logic signed [ACC_W-1:0]     odd_i  [HALF_LEN],
    input  logic                        valid_i,
    output logic [VEC_LEN*OUT_W-1:0]    res_o,
    output logic                        valid_o
);

    localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1) <<< (FRAC_BITS - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    logic [VEC_LEN*OUT_W-1:0] res_n;

    function automatic logic [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] t;
        t = (v + RND) >>> FRAC_BITS;
        if (t > SAT_HI)      t = SAT_HI;
        else if (t < SAT_LO) t = SAT_LO;
        return t[OUT_W-1:0];
    endfunction

    always_comb begin
        res_n = '0;
        for (int k = 0; k < HALF_LEN; k++) begin
            res_n[OUT_W*k +: OUT_W]             = round_sat(even_i[k] + odd_i[k]);
            res_n[OUT_W*(VEC_LEN-1-k) +: OUT_W] = round_sat(even_i[k] - odd_i[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) res_o <= res_n;
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(res_o));

endmodule

// File: rtl/idct8_row.sv
module idct8_row
    import idct8_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_first,
    input  logic [SAMPLE_W-1:0]        in_sample,
    output logic                       out_valid,
    output logic [VEC_LEN*OUT_W-1:0]   out_data
);

    localparam int ACC_W = SAMPLE_W + COEF_W + 3;

    logic signed [SAMPLE_W-1:0] vec   [VEC_LEN];
    logic signed [ACC_W-1:0]    even_s [HALF_LEN];
    logic signed [ACC_W-1:0]    odd_s  [HALF_LEN];
    logic                       go;
    logic                       part_valid;

    idct8_loader #(.SAMPLE_W(SAMPLE_W)) u_load (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_sample ($signed(in_sample)),
        .vec_o     (vec),
        .go_o      (go)
    );

    idct8_partials #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_part (
        .clk     (clk),
        .rst     (rst),
        .vec_i   (vec),
        .go_i    (go),
        .even_o  (even_s),
        .odd_o   (odd_s),
        .valid_o (part_valid)
    );

    idct8_butterfly #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_bfly (
        .clk     (clk),
        .rst     (rst),
        .even_i  (even_s),
        .odd_i   (odd_s),
        .valid_i (part_valid),
        .res_o   (out_data),
        .valid_o (out_valid)
    );

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(go, 2));

endmodule

// File: tb/sim_idct8_row.sv
module sim_idct8_row;

    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         a_valid = 1'b0, a_first = 1'b0;
    logic [11:0]  a_sample = '0;
    logic         a_out_valid;
    logic [127:0] a_out;
    logic         w_valid = 1'b0, w_first = 1'b0;
    logic [15:0]  w_sample = '0;
    logic         w_out_valid;
    logic [127:0] w_out;

    int     total = 0;
    int     bad = 0;
    int     pulses = 0;
    longint vec  [8];
    longint expw [8];

    always #(PERIOD/2) clk = ~clk;

    idct8_row u0 (
        .clk(clk), .rst(rst), .in_valid(a_valid), .in_first(a_first),
        .in_sample(a_sample), .out_valid(a_out_valid), .out_data(a_out)
    );

    idct8_row #(.SAMPLE_W(16), .OUT_W(16)) u1 (
        .clk(clk), .rst(rst), .in_valid(w_valid), .in_first(w_first),
        .in_sample(w_sample), .out_valid(w_out_valid), .out_data(w_out)
    );

    always @(negedge clk) if (!rst && a_out_valid) pulses++;

    function automatic int coef_m(int k, int n);
        int row [8];
        case (k)
            0: row = '{23170,  32138,  30274,  27246,  23170,  18205,  12540,   6393};
            1: row = '{23170,  27246,  12540,  -6393, -23170, -32138, -30274, -18205};
            2: row = '{23170,  18205, -12540, -32138, -23170,   6393,  30274,  27246};
            3: row = '{23170,   6393, -30274, -18205,  23170,  27246, -12540, -32138};
            4: row = '{23170,  -6393, -30274,  18205,  23170, -27246, -12540,  32138};
            5: row = '{23170, -18205, -12540,  32138, -23170,  -6393,  30274, -27246};
            6: row = '{23170, -27246,  12540,   6393, -23170,  32138, -30274,  18205};
            default: row = '{23170, -32138, 30274, -27246, 23170, -18205, 12540, -6393};
        endcase
        return row[n];
    endfunction

    function automatic longint model(int k);
        longint s = 0;
        longint r;
        for (int n = 0; n < 8; n++) s += vec[n] * longint'(coef_m(k, n));
        r = (s + 16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic longint get_word(int which, int k);
        if (which == 0) return longint'($signed(a_out[16*k +: 16]));
        return longint'($signed(w_out[16*k +: 16]));
    endfunction

    function automatic logic get_valid(int which);
        return (which == 0) ? a_out_valid : w_out_valid;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic snap();
        for (int k = 0; k < 8; k++) expw[k] = model(k);
    endtask

    task automatic drive(input int which, input logic v, input logic f, input longint s);
        if (which == 0) begin
            a_valid = v; a_first = f; a_sample = 12'(s);
        end else begin
            w_valid = v; w_first = f; w_sample = 16'(s);
        end
    endtask

    // Drives vec[0..7]; returns right after driving the eighth sample.
    task automatic load_vec(input int which, input int gap);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            drive(which, 1'b1, i == 0, vec[i]);
            if (i < 7) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    drive(which, 1'b0, 1'b0, 0);
                end
            end
        end
    endtask

    // Called at the negedge after the accepting edge.
    task automatic check_result(input int which, input string req);
        @(negedge clk);
        check(get_valid(which) == 1'b0, "R7 early", get_valid(which), 0);
        @(negedge clk);
        check(get_valid(which) == 1'b1, "R7 pulse", get_valid(which), 1);
        for (int k = 0; k < 8; k++)
            check(get_word(which, k) == expw[k], req, get_word(which, k), expw[k]);
        @(negedge clk);
        check(get_valid(which) == 1'b0, "R7 single", get_valid(which), 0);
        for (int k = 0; k < 8; k++)
            check(get_word(which, k) == expw[k], "R7 hold", get_word(which, k), expw[k]);
    endtask

    task automatic run_vec(input int which, input int gap, input string req);
        load_vec(which, gap);
        snap();
        @(negedge clk);
        drive(which, 1'b0, 1'b0, 0);
        check_result(which, req);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(a_out_valid == 1'b0, "R1 valid in reset", a_out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(a_out_valid == 1'b0, "R1 valid", a_out_valid, 0);
        check(a_out == '0, "R1 data", longint'(a_out[63:0]), 0);
    endtask

    task automatic test_patterns();
        for (int i = 0; i < 8; i++) vec[i] = (i == 0) ? 100 : 0;
        run_vec(0, 0, "R3 dc impulse");
        for (int i = 0; i < 8; i++) vec[i] = (i == 3) ? -700 : 0;
        run_vec(0, 0, "R2 single odd tap");
        for (int i = 0; i < 8; i++) vec[i] = i + 1;
        run_vec(0, 0, "R3 ramp");
        for (int i = 0; i < 8; i++) vec[i] = (i % 2 == 0) ? 2047 : -2048;
        run_vec(0, 0, "R3 extremes");
        for (int i = 0; i < 8; i++) vec[i] = -2048;
        run_vec(0, 0, "R3 all min");
        for (int i = 0; i < 8; i++) vec[i] = longint'(((i * 1103 + 517) * 29) % 4096) - 2048;
        run_vec(0, 0, "R3 mixed");
        vec = '{1, 0, 0, 0, 0, 0, 0, 0};
        run_vec(0, 0, "R5 round plus");
        vec = '{-1, 0, 0, 0, 0, 0, 0, 0};
        run_vec(0, 0, "R5 round minus");
    endtask

    task automatic test_even_symmetry();
        vec = '{300, 0, -1200, 0, 850, 0, 2000, 0};
        run_vec(0, 0, "R4 even only");
        for (int k = 0; k < 4; k++)
            check(get_word(0, k) == get_word(0, 7 - k), "R4 mirror", get_word(0, k), get_word(0, 7 - k));
    endtask

    task automatic test_gaps();
        vec = '{-5, 1900, 33, -777, 1024, -1500, 6, 250};
        run_vec(0, 2, "R9 gapped");
    endtask

    task automatic test_stray();
        int p0;
        p0 = pulses;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            drive(0, 1'b1, 1'b0, 1000 + i);
        end
        @(negedge clk);
        drive(0, 1'b0, 1'b0, 0);
        repeat (4) @(negedge clk);
        check(pulses == p0, "R8 stray pulse", pulses - p0, 0);
        for (int k = 0; k < 8; k++)
            check(get_word(0, k) == expw[k], "R8 stray data", get_word(0, k), expw[k]);
    endtask

    task automatic test_restart();
        int p0;
        p0 = pulses;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            drive(0, 1'b1, i == 0, -1999 + i);
        end
        vec = '{12, -34, 560, -780, 910, -1112, 1314, -1516};
        run_vec(0, 0, "R8 restart");
        check(pulses - p0 == 1, "R8 restart pulses", pulses - p0, 1);
    endtask

    task automatic test_back_to_back();
        longint b [8];
        b = '{700, -600, 500, -400, 300, -200, 100, 0};
        vec = '{-1000, 20, 1500, -33, 44, 800, -1700, 9};
        load_vec(0, 0);
        snap();
        vec = b;
        fork
            load_vec(0, 0);
            begin
                @(negedge clk);
                check_result(0, "R10 first vector");
            end
        join
        snap();
        @(negedge clk);
        drive(0, 1'b0, 1'b0, 0);
        check_result(0, "R10 second vector");
    endtask

    task automatic test_saturation();
        for (int i = 0; i < 8; i++) vec[i] = 32767;
        run_vec(1, 0, "R6 positive clamp");
        check(get_word(1, 0) == 32767, "R6 top", get_word(1, 0), 32767);
        for (int i = 0; i < 8; i++) vec[i] = (i % 2 == 0) ? -32768 : 32767;
        run_vec(1, 0, "R6 mixed clamp");
        for (int i = 0; i < 8; i++) vec[i] = -32768;
        run_vec(1, 0, "R6 negative clamp");
        check(get_word(1, 0) == -32768, "R6 bottom", get_word(1, 0), -32768);
    endtask

    initial begin
        #(PERIOD * 50000);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_patterns();
        test_even_symmetry();
        test_gaps();
        test_stray();
        test_restart();
        test_back_to_back();
        test_saturation();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule